// File: doc/BRIEF.md
# Data Access Watchpoint Comparator

This block sits beside a processor's load/store port and watches every data transfer. It does not alter the bus and it does not stall it. Each transfer is compared against a set of programmable watch slots. When a transfer matches an enabled slot, the block raises a one-cycle trap pulse and sets a sticky status bit for that slot. It also records the address and the direction of the first offending access.

Each slot holds an address, an address mask, a data value, a data mask, an access-direction selector and an enable bit. A set bit in a mask marks the matching bit as don't-care. An address mask can therefore cover an aligned block of memory, and a data mask of all ones removes data qualification altogether. Write data is judged in the request cycle. Read data only exists in the response cycle, so a read watch that depends on data is judged when the response arrives.

A two-state tracker follows the bus. In `ST_IDLE`, an accepted read moves it to `ST_RD_WAIT`. In `ST_RD_WAIT`, a response returns it to `ST_IDLE`. Accepted writes leave it in `ST_IDLE`.

Top module: `data_watch_unit`

## Requirements
- R1: After reset, `trap`, `hit_status` and `cap_valid` are 0 and every slot is disabled.
- R2: The address test of a slot passes when `((req_addr ^ ADDR) & ~AMASK) == 0`.
- R3: The data test of a slot passes when `((data ^ DATA) & ~DMASK) == 0`. A DMASK of all ones makes the data test always pass.
- R4: Control bits [2:1] select the access direction: 00 none, 01 reads only, 10 writes only, 11 both.
- R5: An accepted write (`req_valid && req_ready && req_we`) is judged using `req_wdata` in that cycle. `trap` is high in the following cycle.
- R6: An accepted read is judged at request time for slots whose DMASK is all ones. Slots with data qualification judge it in the response cycle, using `resp_rdata` and the address match from the request. Only one read is outstanding at a time.
- R7: A slot whose enable bit (control bit 0) is 0 never fires, whatever its other registers hold.
- R8: `trap` is the OR of all slot hits of the previous cycle and lasts one cycle per hit event.
- R9: `hit_status` bit i is set when slot i hits and stays set until cleared. Writing field 5 with bit i set clears it. A hit in the same cycle as the clear wins.
- R10: On a hit while no status bit remains set, `cap_addr` takes the offending address and `cap_write` takes the direction (1 for write). Both then hold until all status bits are clear. `cap_valid` equals `hit_status != 0`.
- R11: A request with `req_ready` low is ignored and causes no hit.
- R12: Config writes select a register with `cfg_field`: 0 address, 1 data, 2 address mask, 3 data mask, 4 control (bit0 enable, bits[2:1] direction), 5 status clear. Fields 0 to 4 apply to slot `cfg_slot` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_slot | input | 2 | Slot index for fields 0 to 4 |
| cfg_field | input | 3 | Register select |
| cfg_wdata | input | 32 | Config write value |
| req_valid | input | 1 | Processor request valid |
| req_ready | input | 1 | Bus accepts the request |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| resp_valid | input | 1 | Read response valid |
| resp_rdata | input | 32 | Read response data |
| trap | output | 1 | One-cycle trap pulse |
| hit_status | output | 4 | Sticky per-slot hit flags |
| cap_valid | output | 1 | Capture registers hold a hit |
| cap_addr | output | 32 | Address of first captured hit |
| cap_write | output | 1 | Direction of first captured hit |

## Verification
The assertions assume a bus that keeps at most one read in flight. No request is accepted while the tracker sits in `ST_RD_WAIT`. The stimulus honours this by idling the request side until each read response has been driven. It also never rewrites a slot between a read request and its response, so the data judgement uses the configuration in place at the request. Random accesses are drawn from a small address window that the slot addresses share, so that hits, misses and mask coverage all occur for every direction setting.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
    typedef enum logic [2:0] {
        FLD_ADDR  = 3'd0,
        FLD_DATA  = 3'd1,
        FLD_AMASK = 3'd2,
        FLD_DMASK = 3'd3,
        FLD_CTRL  = 3'd4,
        FLD_CLEAR = 3'd5
    } cfg_field_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RD   = 2'b01,
        ACC_WR   = 2'b10,
        ACC_BOTH = 2'b11
    } acc_sel_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RD_WAIT = 1'b1
    } bus_state_e;
endpackage

// File: rtl/dwu_bus_track.sv
module dwu_bus_track
    import dwu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic          resp_valid,
    output logic          wr_fire,
    output logic          rd_fire,
    output logic          rsp_fire,
    output logic [AW-1:0] rd_addr
);
    bus_state_e state_q, state_d;
    logic       accept;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept && !req_we) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (resp_valid)        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_fire  = 1'b0;
        rd_fire  = 1'b0;
        rsp_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_fire = accept && req_we;
                rd_fire = accept && !req_we;
            end
            ST_RD_WAIT: rsp_fire = resp_valid;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rd_addr <= '0;
        else if (rd_fire) rd_addr <= req_addr;
    end

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_WAIT) |-> !(req_valid && req_ready)); // R6
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fire |-> (state_q == ST_RD_WAIT)); // R6
endmodule

// File: rtl/dwu_slot.sv
module dwu_slot
    import dwu_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_field,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          wr_fire,
    input  logic          rd_fire,
    input  logic          rsp_fire,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] resp_rdata,
    output logic          hit
);
    logic [AW-1:0] a_q, am_q;
    logic [DW-1:0] d_q, dm_q;
    logic          en_q;
    acc_sel_e      acc_q;
    logic          rd_amatch_q;

    logic amatch, dmatch_w, dmatch_r, addr_only, allow_rd, allow_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            am_q  <= '0;
            d_q   <= '0;
            dm_q  <= '0;
            en_q  <= 1'b0;
            acc_q <= ACC_NONE;
        end else if (cfg_we) begin
            case (cfg_field)
                FLD_ADDR:  a_q  <= cfg_wdata[AW-1:0];
                FLD_DATA:  d_q  <= cfg_wdata;
                FLD_AMASK: am_q <= cfg_wdata[AW-1:0];
                FLD_DMASK: dm_q <= cfg_wdata;
                FLD_CTRL: begin
                    en_q  <= cfg_wdata[0];
                    acc_q <= acc_sel_e'(cfg_wdata[2:1]);
                end
                default: ;
            endcase
        end
    end

    assign amatch    = ((req_addr ^ a_q) & ~am_q) == '0;
    assign dmatch_w  = ((req_wdata ^ d_q) & ~dm_q) == '0;
    assign dmatch_r  = ((resp_rdata ^ d_q) & ~dm_q) == '0;
    assign addr_only = &dm_q;
    assign allow_rd  = (acc_q == ACC_RD) || (acc_q == ACC_BOTH);
    assign allow_wr  = (acc_q == ACC_WR) || (acc_q == ACC_BOTH);

    always_ff @(posedge clk) begin
        if (!rst_n)       rd_amatch_q <= 1'b0;
        else if (rd_fire) rd_amatch_q <= amatch;
    end

    assign hit = en_q && (
        (wr_fire  && allow_wr && amatch && dmatch_w) ||
        (rd_fire  && allow_rd && addr_only && amatch) ||
        (rsp_fire && allow_rd && !addr_only && rd_amatch_q && dmatch_r));

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !hit); // R7
    AST_NO_IDLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire || rd_fire || rsp_fire) |-> !hit); // R11
    AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == ACC_NONE) |-> !hit); // R4
endmodule

// File: rtl/dwu_capture.sv
module dwu_capture #(
    parameter int AW    = 32,
    parameter int NSLOT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] hits,
    input  logic             clr_we,
    input  logic [NSLOT-1:0] clr_bits,
    input  logic [AW-1:0]    evt_addr,
    input  logic             evt_write,
    output logic             trap,
    output logic [NSLOT-1:0] status,
    output logic             cap_valid,
    output logic [AW-1:0]    cap_addr,
    output logic             cap_write
);
    logic [NSLOT-1:0] clr_mask, kept;
    logic             any_hit;

    assign clr_mask = clr_we ? clr_bits : '0;
    assign kept     = status & ~clr_mask;
    assign any_hit  = |hits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap      <= 1'b0;
            status    <= '0;
            cap_valid <= 1'b0;
            cap_addr  <= '0;
            cap_write <= 1'b0;
        end else begin
            trap      <= any_hit;
            status    <= kept | hits;
            cap_valid <= |(kept | hits);
            if (any_hit && (kept == '0)) begin
                cap_addr  <= evt_addr;
                cap_write <= evt_write;
            end
        end
    end

    AST_TRAP_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (status != '0)); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status & $past(status)) == $past(status))); // R9
    AST_CAPV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid == (status != '0)); // R10
    AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && ((status & clr_mask) == '0)) |=> ($stable(cap_addr) && $stable(cap_write))); // R10
endmodule

// File: rtl/data_watch_unit.sv
module data_watch_unit
    import dwu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NSLOT = 4,
    localparam int SIW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SIW-1:0]   cfg_slot,
    input  logic [2:0]       cfg_field,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic             req_valid,
    input  logic             req_ready,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             resp_valid,
    input  logic [DW-1:0]    resp_rdata,
    output logic             trap,
    output logic [NSLOT-1:0] hit_status,
    output logic             cap_valid,
    output logic [AW-1:0]    cap_addr,
    output logic             cap_write
);
    logic             wr_fire, rd_fire, rsp_fire;
    logic [AW-1:0]    rd_addr;
    logic [NSLOT-1:0] hits;
    logic             clr_we;
    logic [AW-1:0]    evt_addr;

    dwu_bus_track #(.AW(AW)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .resp_valid (resp_valid),
        .wr_fire    (wr_fire),
        .rd_fire    (rd_fire),
        .rsp_fire   (rsp_fire),
        .rd_addr    (rd_addr)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic sel_we;
        assign sel_we = cfg_we && (cfg_slot == SIW'(i)) && (cfg_field != FLD_CLEAR);

        dwu_slot #(.AW(AW), .DW(DW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (sel_we),
            .cfg_field  (cfg_field),
            .cfg_wdata  (cfg_wdata),
            .wr_fire    (wr_fire),
            .rd_fire    (rd_fire),
            .rsp_fire   (rsp_fire),
            .req_addr   (req_addr),
            .req_wdata  (req_wdata),
            .resp_rdata (resp_rdata),
            .hit        (hits[i])
        );
    end

    assign clr_we   = cfg_we && (cfg_field == FLD_CLEAR);
    assign evt_addr = rsp_fire ? rd_addr : req_addr;

    dwu_capture #(.AW(AW), .NSLOT(NSLOT)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .hits      (hits),
        .clr_we    (clr_we),
        .clr_bits  (cfg_wdata[NSLOT-1:0]),
        .evt_addr  (evt_addr),
        .evt_write (wr_fire),
        .trap      (trap),
        .status    (hit_status),
        .cap_valid (cap_valid),
        .cap_addr  (cap_addr),
        .cap_write (cap_write)
    );

    AST_TRAP_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |=> trap); // R8
    AST_TRAP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hits == '0) |=> !trap); // R8
endmodule

// File: tb/tb_data_watch_unit.sv
module tb_data_watch_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [2:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_ready = 1'b1, req_we = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        resp_valid = 1'b0;
    logic [31:0] resp_rdata = '0;
    logic        trap, cap_valid, cap_write;
    logic [3:0]  hit_status;
    logic [31:0] cap_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    data_watch_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .trap(trap), .hit_status(hit_status), .cap_valid(cap_valid),
        .cap_addr(cap_addr), .cap_write(cap_write)
    );

    typedef struct {
        logic        trap;
        logic [3:0]  st;
        logic        cv;
        logic [31:0] ca;
        logic        cw;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0;
    bit done = 0;

    // bench record of what it has programmed
    logic [31:0] ba[4], bd[4], bam[4], bdm[4];
    logic        ben[4];
    logic [1:0]  bacc[4];
    logic [3:0]  ms = '0;
    logic [31:0] mca = '0;
    logic        mcw = 1'b0;
    logic        pend = 1'b0;
    logic [31:0] rda = '0;
    logic        ram[4];

    task automatic check(input bit ok, input string what, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compares one expectation per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(trap == e.trap, "trap", e.tag, 32'(trap), 32'(e.trap));
                check(hit_status == e.st, "status", e.tag, 32'(hit_status), 32'(e.st));
                check(cap_valid == e.cv, "cap_valid", e.tag, 32'(cap_valid), 32'(e.cv));
                if (e.cv) begin
                    check(cap_addr == e.ca, "cap_addr", e.tag, cap_addr, e.ca);
                    check(cap_write == e.cw, "cap_write", e.tag, 32'(cap_write), 32'(e.cw));
                end
            end
        end
    end

    // driver: models the current cycle, pushes the expectation, advances
    task automatic cyc(input string tag);
        exp_t e;
        logic [3:0] h, clr, kept;
        logic wf, rf, sf;
        wf = req_valid && req_ready && req_we && !pend;
        rf = req_valid && req_ready && !req_we && !pend;
        sf = pend && resp_valid;
        h = '0;
        for (int i = 0; i < 4; i++) begin
            logic am, ao;
            am = ((req_addr ^ ba[i]) & ~bam[i]) == 0;
            ao = &bdm[i];
            if (ben[i]) begin
                if (wf && bacc[i][1] && am && (((req_wdata ^ bd[i]) & ~bdm[i]) == 0)) h[i] = 1'b1;
                if (rf && bacc[i][0] && ao && am) h[i] = 1'b1;
                if (sf && bacc[i][0] && !ao && ram[i] && (((resp_rdata ^ bd[i]) & ~bdm[i]) == 0)) h[i] = 1'b1;
            end
            if (rf) ram[i] = am;
        end
        clr  = (cfg_we && cfg_field == 3'd5) ? cfg_wdata[3:0] : 4'h0;
        kept = ms & ~clr;
        if (h != 0 && kept == 0) begin
            mca = sf ? rda : req_addr;
            mcw = wf;
        end
        ms = kept | h;
        e.trap = |h; e.st = ms; e.cv = (ms != 0); e.ca = mca; e.cw = mcw; e.tag = tag;
        if (cfg_we) begin
            case (cfg_field)
                3'd0: ba[cfg_slot]  = cfg_wdata;
                3'd1: bd[cfg_slot]  = cfg_wdata;
                3'd2: bam[cfg_slot] = cfg_wdata;
                3'd3: bdm[cfg_slot] = cfg_wdata;
                3'd4: begin ben[cfg_slot] = cfg_wdata[0]; bacc[cfg_slot] = cfg_wdata[2:1]; end
                default: ;
            endcase
        end
        if (rf) begin pend = 1'b1; rda = req_addr; end
        else if (sf) pend = 1'b0;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        cfg_we = 0; req_valid = 0; resp_valid = 0;
        cyc(tag);
    endtask

    task automatic cfg(input int s, input int f, input logic [31:0] v);
        cfg_we = 1; cfg_slot = 2'(s); cfg_field = 3'(f); cfg_wdata = v;
        req_valid = 0; resp_valid = 0;
        cyc("R12");
        cfg_we = 0;
    endtask

    task automatic prog(input int s, input logic [31:0] a, input logic [31:0] am,
                        input logic [31:0] d, input logic [31:0] dm, input logic [2:0] ctrl);
        cfg(s, 0, a); cfg(s, 2, am); cfg(s, 1, d); cfg(s, 3, dm); cfg(s, 4, {29'd0, ctrl});
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit rdy, input string tag);
        req_valid = 1; req_we = 1; req_addr = a; req_wdata = d; req_ready = rdy;
        cyc(tag);
        req_valid = 0; req_ready = 1;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] d, input int gap, input string tag);
        req_valid = 1; req_we = 0; req_addr = a; req_ready = 1;
        cyc(tag);
        req_valid = 0;
        for (int g = 0; g < gap; g++) cyc(tag);
        resp_valid = 1; resp_rdata = d;
        cyc(tag);
        resp_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            ba[i] = 0; bd[i] = 0; bam[i] = 0; bdm[i] = 0; ben[i] = 0; bacc[i] = 0; ram[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state seen at the ports
        check(trap == 0, "trap", "R1", 32'(trap), 0);
        check(hit_status == 0, "status", "R1", 32'(hit_status), 0);
        check(cap_valid == 0, "cap_valid", "R1", 32'(cap_valid), 0);
        wr(32'h0, 32'h0, 1, "R1 R7");
        rd(32'h0, 32'h0, 0, "R1 R7");

        // R2 address with mask, both directions, address only
        prog(0, 32'h40, 32'hF, 32'h0, 32'hFFFF_FFFF, 3'b111);
        wr(32'h4C, 32'h1234, 1, "R2 R5");
        rd(32'h45, 32'h9, 1, "R2 R6");
        wr(32'h50, 32'h0, 1, "R2");
        cfg(0, 5, 32'hF);  // R9 clear

        // R3 data qualified write slot
        prog(1, 32'h80, 32'h0, 32'hAB, 32'h0, 3'b101);
        wr(32'h80, 32'hAB, 1, "R3 R5");
        wr(32'h80, 32'hAC, 1, "R3");
        rd(32'h80, 32'hAB, 0, "R4");
        cfg(0, 5, 32'hF);

        // R6 data qualified read judged at the response
        prog(2, 32'h90, 32'h0, 32'h5, 32'h0, 3'b011);
        rd(32'h90, 32'h5, 2, "R6");
        rd(32'h90, 32'h6, 0, "R6 R3");
        rd(32'h91, 32'h5, 1, "R6 R2");

        // R7 disabled slot with a matching setup
        prog(3, 32'hA0, 32'h0, 32'h0, 32'hFFFF_FFFF, 3'b110);
        wr(32'hA0, 32'h0, 1, "R7");
        // R4 direction none
        cfg(3, 4, 32'h1);
        wr(32'hA0, 32'h0, 1, "R4");
        rd(32'hA0, 32'h0, 0, "R4");

        // R11 stalled request
        cfg(0, 5, 32'hF);
        wr(32'h40, 32'h0, 0, "R11");
        idle("R11");

        // R10 first capture held, R9 partial clear
        wr(32'h41, 32'h0, 1, "R10");
        wr(32'h80, 32'hAB, 1, "R10 R8");
        cfg(0, 5, 32'h1);
        idle("R9 R10");
        cfg(0, 5, 32'h2);
        // R9 set wins over clear in the same cycle
        wr(32'h80, 32'hAB, 1, "R10");
        cfg_we = 1; cfg_field = 3'd5; cfg_wdata = 32'h2;
        req_valid = 1; req_we = 1; req_addr = 32'h80; req_wdata = 32'hAB;
        cyc("R9");
        cfg_we = 0; req_valid = 0;
        idle("R9 R8");

        // random accesses over every direction setting
        for (int blk = 0; blk < 12; blk++) begin
            for (int s = 0; s < 4; s++) begin
                logic [31:0] am_c, dm_c;
                case ($urandom % 4)
                    0: am_c = 32'h0; 1: am_c = 32'h3; 2: am_c = 32'hF; default: am_c = 32'hFF;
                endcase
                case ($urandom % 3)
                    0: dm_c = 32'hFFFF_FFFF; 1: dm_c = 32'h0; default: dm_c = 32'hFFFF_FFFE;
                endcase
                prog(s, 32'($urandom % 256), am_c, 32'($urandom % 4), dm_c,
                     {2'(blk % 4), 1'(($urandom % 4) != 0)});
            end
            for (int n = 0; n < 40; n++) begin
                logic [31:0] a;
                a = ($urandom % 2) ? ba[$urandom % 4] ^ 32'($urandom % 4) : 32'($urandom % 256);
                case ($urandom % 5)
                    0, 1: wr(a, 32'($urandom % 4), 1, "R2 R3 R4 R5 R8");
                    2, 3: rd(a, 32'($urandom % 4), $urandom % 3, "R2 R3 R4 R6 R8");
                    default: begin
                        if ($urandom % 2) wr(a, 32'($urandom % 4), 0, "R11");
                        else cfg(0, 5, 32'($urandom % 16));
                    end
                endcase
            end
        end

        repeat (3) idle("R8");
        @(posedge clk); #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule